// File: doc/BRIEF.md
# DMA Channel Request Qualifier

This block sits in front of the bus transfer engine of a four-channel DMA controller. It decides, cycle by cycle, whether each channel has a transfer request that the engine may act on. Each channel has a 4-bit request-source code, which selects one of three origins. The first is a request the block generates internally and holds for as long as the channel may run. The second is an active-low external request pin, which exists on channels 0 and 1 only. The third is one of six request lines from on-chip peripherals.

A channel may request only when all five conditions hold: its own enable is set, its end-of-transfer flag is clear, the global master enable is set, and the global address-error and NMI flags are clear. For external requests, a per-channel sense bit picks low-level or falling-edge detection. A falling edge is held as a pending request until the engine acknowledges it. The block also decodes the external codes into the addressing mode (dual or single) and, for single-address transfers, the direction.

Top module: `dmaq_top`

## Requirements
- R1: `reqOut[c]` is 1 only when `chanEnable[c]`=1, `masterEnable`=1, `xferEnd[c]`=0, `addrError`=0 and `nmiFlag`=0. Clearing any one of these five conditions removes the request in the same cycle.
- R2: Code 4'h4 (self-generated) drives `reqOut[c]`=1 combinationally for every cycle in which the R1 condition holds. It needs no input line, and `size16` has no effect on it.
- R3: With code 4'h0, 4'h2 or 4'h3 on channel 0 or 1 and `edgeSense[c]`=0, `reqOut[c]` follows the inverted, synchronized `dreqN[c]`. It becomes 1 after the second rising clock edge that samples the pin low, and becomes 0 after the second rising edge that samples it high again.
- R4: With an external code and `edgeSense[c]`=1, a high-to-low change of `dreqN[c]` sets a pending request. `reqOut[c]` rises after the third rising edge that samples the pin low and stays 1 while the pin stays low. It clears after the rising edge at which `dreqAck[c]`=1.
- R5: Code 4'h0 gives dual-address mode (`singleAddr`=0, `toDevice`=0). Code 4'h2 gives single-address mode, memory to device (`singleAddr`=1, `toDevice`=1). Code 4'h3 gives single-address mode, device to memory (`singleAddr`=1, `toDevice`=0). This applies on channels 0 and 1. Every other code gives 0 on both outputs.
- R6: The codes 4'h1, 4'h5, 4'h6, 4'h7, 4'hE and 4'hF never produce a request. External codes (4'h0, 4'h2, 4'h3) on channels 2 and 3 also never produce a request and decode to `singleAddr`=0.
- R7: Codes 4'h8 to 4'hD select peripheral line `periphReq[code-8]`. The line order is: 0 = serial A receive full, 1 = serial A transmit empty, 2 = serial B receive full, 3 = serial B transmit empty, 4 = A/D conversion end, 5 = timer compare match. `reqOut[c]` follows the selected line combinationally while R1 holds.
- R8: When `size16[c]`=1 (16-byte transfer unit), peripheral codes 4'h8 to 4'hD produce no request on that channel.
- R9: A pending edge request is discarded in the first clock edge during which the R1 condition is false for that channel. After the condition is restored, a new falling edge is needed.
- R10: After reset, no edge request is pending and the synchronizers read the pin as inactive (high), so a pin that is already high creates no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSel | input | 16 | Request-source code, 4 bits per channel, channel c at bits [4c+3:4c] |
| chanEnable | input | 4 | Per-channel enable |
| xferEnd | input | 4 | Per-channel end-of-transfer flag |
| masterEnable | input | 1 | Global DMA enable |
| addrError | input | 1 | Global address-error flag |
| nmiFlag | input | 1 | Global NMI flag |
| edgeSense | input | 2 | Channel 0/1 sense select: 0 low level, 1 falling edge |
| size16 | input | 4 | Per-channel 16-byte transfer unit in use |
| dreqN | input | 2 | Active-low external request, channels 0 and 1 |
| dreqAck | input | 2 | Engine acknowledge of an edge request, channels 0 and 1 |
| periphReq | input | 6 | On-chip peripheral request lines (order in R7) |
| reqOut | output | 4 | Qualified request per channel |
| singleAddr | output | 4 | 1 = single-address mode, 0 = dual |
| toDevice | output | 4 | Single-address direction: 1 memory to device |

## Verification
A wrong pending bit shows up at `reqOut` as soon as it exists. A bit stuck at 1 gives a request with no new falling edge after an acknowledge, or after the enable has gone away and come back. A bit that fails to set leaves `reqOut` low three edges after the pin falls. A synchronizer stage that is missing or extra moves the level-mode request by one cycle, so the bench samples at the exact edge count on both rising and falling transitions. Decode faults are purely combinational, so they appear on `reqOut`, `singleAddr` or `toDevice` in the same cycle as the code change.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_EXT_DUAL = 4'h0;
  localparam logic [CODE_W-1:0] CODE_EXT_TODEV = 4'h2;
  localparam logic [CODE_W-1:0] CODE_EXT_FROMDEV = 4'h3;
  localparam logic [CODE_W-1:0] CODE_AUTO = 4'h4;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic qualified;
    logic isAuto;
    logic periphHit;
    logic extLevel;
    logic extEdge;
  } chanStrobe_t;

endpackage

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl
  import dmaq_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int NUM_EXT    = 2,
  parameter int NUM_PERIPH = 6
) (
  input  logic [NUM_CH*CODE_W-1:0]  srcSel,
  input  logic [NUM_CH-1:0]         chanEnable,
  input  logic [NUM_CH-1:0]         xferEnd,
  input  logic                      masterEnable,
  input  logic                      addrError,
  input  logic                      nmiFlag,
  input  logic [NUM_EXT-1:0]        edgeSense,
  input  logic [NUM_CH-1:0]         size16,
  input  logic [NUM_PERIPH-1:0]     periphReq,
  output chanStrobe_t [NUM_CH-1:0]  strobe,
  output logic [NUM_CH-1:0]         singleAddr,
  output logic [NUM_CH-1:0]         toDevice
);

  localparam int IDX_W    = CODE_W - 1;
  localparam int PER_SPAN = 2 ** IDX_W;

  logic globalOk;
  logic [PER_SPAN-1:0] perPad;

  assign globalOk = masterEnable & ~addrError & ~nmiFlag;
  assign perPad   = PER_SPAN'(periphReq);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CODE_W-1:0] code;
    logic [IDX_W-1:0]  perIdx;
    logic isExtCode, isPerCode, extHere, senseEdge;
    chanStrobe_t s;

    assign code   = srcSel[c*CODE_W +: CODE_W];
    assign perIdx = code[IDX_W-1:0];

    if (c < NUM_EXT) begin : g_ext
      assign extHere   = 1'b1;
      assign senseEdge = edgeSense[c];
    end else begin : g_noext
      assign extHere   = 1'b0;
      assign senseEdge = 1'b0;
    end

    always_comb begin
      isExtCode = extHere && (code == CODE_EXT_DUAL || code == CODE_EXT_TODEV ||
                              code == CODE_EXT_FROMDEV);
      isPerCode = code[CODE_W-1] && (int'(perIdx) < NUM_PERIPH);
      s.qualified = chanEnable[c] & ~xferEnd[c] & globalOk;
      s.isAuto    = (code == CODE_AUTO);
      s.periphHit = isPerCode & ~size16[c] & perPad[perIdx];
      s.extLevel  = isExtCode & ~senseEdge;
      s.extEdge   = isExtCode & senseEdge;
    end

    assign strobe[c]     = s;
    assign singleAddr[c] = extHere && (code == CODE_EXT_TODEV || code == CODE_EXT_FROMDEV);
    assign toDevice[c]   = extHere && (code == CODE_EXT_TODEV);
  end

endmodule

// File: rtl/dmaq_dpath.sv
module dmaq_dpath
  import dmaq_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_EXT = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_EXT-1:0]       dreqN,
  input  logic [NUM_EXT-1:0]       dreqAck,
  input  chanStrobe_t [NUM_CH-1:0] strobe,
  output logic [NUM_CH-1:0]        reqOut
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chanStrobe_t st;
    logic lvlLow, pendHit;
    assign st = strobe[c];

    if (c < NUM_EXT) begin : g_ext
      logic syncA, syncB, syncPrev, pend, fallSeen;
      assign fallSeen = ~syncB & syncPrev;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA    <= 1'b1;
          syncB    <= 1'b1;
          syncPrev <= 1'b1;
          pend     <= 1'b0;
        end else begin
          syncA    <= dreqN[c];
          syncB    <= syncA;
          syncPrev <= syncB;
          pend     <= st.qualified & st.extEdge & (fallSeen | (pend & ~dreqAck[c]));
        end
      end

      assign lvlLow  = ~syncB;
      assign pendHit = pend;

      assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
        !st.qualified |=> !pend);
      assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
        (pend && !dreqAck[c] && st.qualified && st.extEdge) |=> pend);
      assert_sync_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
        (pend && !$past(pend)) |-> !syncPrev);
    end else begin : g_noext
      assign lvlLow  = 1'b0;
      assign pendHit = 1'b0;
    end

    assign reqOut[c] = st.qualified & (st.isAuto | st.periphHit |
                       (st.extLevel & lvlLow) | (st.extEdge & pendHit));
  end

endmodule

// File: rtl/dmaq_top.sv
module dmaq_top
  import dmaq_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int NUM_EXT    = 2,
  parameter int NUM_PERIPH = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CH*CODE_W-1:0]  srcSel,
  input  logic [NUM_CH-1:0]         chanEnable,
  input  logic [NUM_CH-1:0]         xferEnd,
  input  logic                      masterEnable,
  input  logic                      addrError,
  input  logic                      nmiFlag,
  input  logic [NUM_EXT-1:0]        edgeSense,
  input  logic [NUM_CH-1:0]         size16,
  input  logic [NUM_EXT-1:0]        dreqN,
  input  logic [NUM_EXT-1:0]        dreqAck,
  input  logic [NUM_PERIPH-1:0]     periphReq,
  output logic [NUM_CH-1:0]         reqOut,
  output logic [NUM_CH-1:0]         singleAddr,
  output logic [NUM_CH-1:0]         toDevice
);

  chanStrobe_t [NUM_CH-1:0] strobe;

  dmaq_ctrl #(.NUM_CH(NUM_CH), .NUM_EXT(NUM_EXT), .NUM_PERIPH(NUM_PERIPH)) u_ctrl (
    .srcSel(srcSel), .chanEnable(chanEnable), .xferEnd(xferEnd),
    .masterEnable(masterEnable), .addrError(addrError), .nmiFlag(nmiFlag),
    .edgeSense(edgeSense), .size16(size16), .periphReq(periphReq),
    .strobe(strobe), .singleAddr(singleAddr), .toDevice(toDevice)
  );

  dmaq_dpath #(.NUM_CH(NUM_CH), .NUM_EXT(NUM_EXT)) u_dpath (
    .clk(clk), .rstN(rstN), .dreqN(dreqN), .dreqAck(dreqAck),
    .strobe(strobe), .reqOut(reqOut)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic [CODE_W-1:0] cd;
    logic badCode;
    assign cd = srcSel[c*CODE_W +: CODE_W];
    assign badCode = (cd == 4'h1) || (cd == 4'h5) || (cd == 4'h6) || (cd == 4'h7) ||
                     (cd == 4'hE) || (cd == 4'hF) ||
                     ((c >= NUM_EXT) && (cd == 4'h0 || cd == 4'h2 || cd == 4'h3));

    assert_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
      reqOut[c] |-> (chanEnable[c] && masterEnable && !xferEnd[c] && !addrError && !nmiFlag));
    assert_no_big_periph_R8: assert property (@(posedge clk) disable iff (!rstN)
      (size16[c] && cd[CODE_W-1]) |-> !reqOut[c]);
    assert_bad_code_R6: assert property (@(posedge clk) disable iff (!rstN)
      badCode |-> (!reqOut[c] && !singleAddr[c]));
  end

endmodule

// File: tb/test_dmaq_top.sv
module test_dmaq_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] srcSel = '0;
  logic [3:0] chanEnable = '0, xferEnd = '0, size16 = '0;
  logic masterEnable = 1'b0, addrError = 1'b0, nmiFlag = 1'b0;
  logic [1:0] edgeSense = '0, dreqN = 2'b11, dreqAck = '0;
  logic [5:0] periphReq = '0;
  logic [3:0] reqOut, singleAddr, toDevice;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dmaq_top i_dmaq_top (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .chanEnable(chanEnable),
    .xferEnd(xferEnd), .masterEnable(masterEnable), .addrError(addrError),
    .nmiFlag(nmiFlag), .edgeSense(edgeSense), .size16(size16), .dreqN(dreqN),
    .dreqAck(dreqAck), .periphReq(periphReq), .reqOut(reqOut),
    .singleAddr(singleAddr), .toDevice(toDevice)
  );

  // {sel16, en4, te4, me, ae, nmi, sz4, per6, expReq4, expSingle4, expDir4}
  localparam int NV = 13;
  localparam logic [48:0] VEC [NV] = '{
    {16'h4444, 4'hF, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 6'h00, 4'hF, 4'h0, 4'h0}, // R2 auto
    {16'h4444, 4'hF, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 6'h00, 4'h0, 4'h0, 4'h0}, // R1 master off
    {16'h4444, 4'hF, 4'h0, 1'b1, 1'b1, 1'b0, 4'h0, 6'h00, 4'h0, 4'h0, 4'h0}, // R1 addr error
    {16'h4444, 4'hF, 4'h0, 1'b1, 1'b0, 1'b1, 4'h0, 6'h00, 4'h0, 4'h0, 4'h0}, // R1 nmi
    {16'h4444, 4'hF, 4'h5, 1'b1, 1'b0, 1'b0, 4'h0, 6'h00, 4'hA, 4'h0, 4'h0}, // R1 xfer end
    {16'h4444, 4'h3, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 6'h00, 4'h3, 4'h0, 4'h0}, // R1 chan enable
    {16'h89AB, 4'hF, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 6'h05, 4'hA, 4'h0, 4'h0}, // R7 lines 0..3
    {16'hCDCD, 4'hF, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 6'h10, 4'hA, 4'h0, 4'h0}, // R7 lines 4,5
    {16'h89AB, 4'hF, 4'h0, 1'b1, 1'b0, 1'b0, 4'h8, 6'h05, 4'h2, 4'h0, 4'h0}, // R8 16-byte block
    {16'h4444, 4'hF, 4'h0, 1'b1, 1'b0, 1'b0, 4'hF, 6'h00, 4'hF, 4'h0, 4'h0}, // R2 size16 ignored
    {16'h0232, 4'hF, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 6'h00, 4'h0, 4'h3, 4'h1}, // R5 R6 decode
    {16'hF70E, 4'hF, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 6'h3F, 4'h0, 4'h0, 4'h0}, // R6 undefined
    {16'hE561, 4'hF, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 6'h3F, 4'h0, 4'h0, 4'h0}  // R6 undefined
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    edges(3);
    rstN = 1'b1;
    edges(1);
    chk("R10 reset reqOut", reqOut, 4'h0);

    // ---- table of combinational vectors ----
    for (int i = 0; i < NV; i++) begin
      {srcSel, chanEnable, xferEnd, masterEnable, addrError, nmiFlag,
       size16, periphReq} = VEC[i][48:12];
      #5;
      chk($sformatf("R1/R2/R5/R6/R7/R8 vec%0d reqOut", i), reqOut, VEC[i][11:8]);
      chk($sformatf("R5 vec%0d singleAddr", i), singleAddr, VEC[i][7:4]);
      chk($sformatf("R5 vec%0d toDevice", i), toDevice, VEC[i][3:0]);
      edges(1);
    end

    // ---- R10: edge mode after reset, pin high, no request ----
    srcSel = 16'h0030; chanEnable = 4'hF; xferEnd = 4'h0; masterEnable = 1'b1;
    addrError = 1'b0; nmiFlag = 1'b0; size16 = 4'h0; periphReq = '0;
    edgeSense = 2'b10; dreqN = 2'b11;
    edges(4);
    chk("R10 no spurious edge", reqOut, 4'h0);

    // ---- R3: level sensing on channel 0 ----
    srcSel = 16'h0000; edgeSense = 2'b00;
    edges(1);
    dreqN[0] = 1'b0;
    edges(1);
    chk("R3 level after one edge", reqOut, 4'h0);
    edges(1);
    chk("R3 level after two edges", reqOut, 4'h1);
    dreqN[0] = 1'b1;
    edges(1);
    chk("R3 release after one edge", reqOut, 4'h1);
    edges(1);
    chk("R3 release after two edges", reqOut, 4'h0);

    // ---- R4: edge sensing on channel 1 ----
    srcSel = 16'h0030; edgeSense = 2'b10;
    edges(2);
    dreqN[1] = 1'b0;
    edges(2);
    chk("R4 edge after two edges", reqOut, 4'h0);
    edges(1);
    chk("R4 edge after three edges", reqOut, 4'h2);
    edges(3);
    chk("R4 pending held", reqOut, 4'h2);
    dreqAck = 2'b10;
    edges(1);
    dreqAck = 2'b00;
    #1;
    chk("R4 cleared by ack", reqOut, 4'h0);
    edges(3);
    chk("R4 no re-fire while pin low", reqOut, 4'h0);

    // ---- R9: enable loss discards pending ----
    dreqN[1] = 1'b1;
    edges(3);
    dreqN[1] = 1'b0;
    edges(3);
    chk("R9 pending set", reqOut, 4'h2);
    masterEnable = 1'b0;
    #1;
    chk("R9 request drops with enable", reqOut, 4'h0);
    edges(1);
    masterEnable = 1'b1;
    #1;
    chk("R9 pending discarded", reqOut, 4'h0);
    edges(3);
    chk("R9 stays clear without new edge", reqOut, 4'h0);

    // ---- R6: external code on channel 2 ignores pins ----
    srcSel = 16'h0200; edgeSense = 2'b00; dreqN = 2'b00;
    edges(3);
    chk("R6 ext code on ch2 no request", reqOut & 4'hC, 4'h0);
    chk("R5 channel 0/1 dual", singleAddr, 4'h0);

    summary();
  end

endmodule